// File: doc/BRIEF.md
# Snoop Response Decision Unit for a Miss Entry

This block sits beside one outstanding-miss entry of a cache and judges each snoop that hits the entry's line. It takes the snoop's attributes and a snapshot of the entry's state. From these it decides whether the entry answers the snoop and whether a copy of the snoop is kept for replay once the miss completes. It also produces the marks the cache applies to the snoop on its way out, and the updates to the entry's pending-invalidate and pending-downgrade bookkeeping.

The first question is ordering. If the miss has not been issued yet, or it was issued but is still held in a lower cache that is forwarding this snoop on the fast path, then the snoop logically comes before the miss. In that case the snoop leaves the entry alone. An invalidating snoop still asks that buffered upgrades be turned into full exclusive reads. Otherwise the miss comes first, and the entry may become the ordering point for the line.

Each decision is made from one strobe cycle. The results come out of a register stage together with a valid flag, so the entry applies its flag updates on the following cycle.

Top module: `snoop_decide`

## Requirements
- R1: When the entry is not in service, or the snoop is express while downstream-pending is set, the result has respond, replay, all four snoop marks and both flag updates at 0, and convert-upgrades equals needs-writable OR cache-invalidate.
- R2: When the miss precedes the snoop (in service, and not express-with-downstream-pending), convert-upgrades also equals needs-writable OR cache-invalidate.
- R3: In the R2 case, if the entry's post-invalidate is set or its head target is a cache-invalidate, then respond is 1 and replay, the marks and the flag updates are all 0.
- R4: Otherwise respond = pending-modified AND needs-response AND NOT clean.
- R5: Otherwise replay = pending-modified OR invalidate.
- R6: Whenever respond is 1 in the R4 case, cache-responding and responder-had-writable are both 1. Otherwise they are 0.
- R7: Satisfied is 1 only when pending-modified and clean are set and respond is 0.
- R8: Set-post-invalidate is 1 when replay is 1 and the snoop needs writable or invalidates.
- R9: In the R4 case, a snoop that neither needs writable nor is uncacheable raises both set-post-downgrade and has-sharers.
- R10: The attribute-error output is 1 for any strobed snoop whose needs-writable differs from its invalidate attribute and that is not cache-maintenance, whichever path it takes.
- R11: With OUT_STAGES = 1, the results and rsp_valid appear one clock after the strobe. In a cycle with rsp_valid at 0, every result output is 0.
- R12: During and just after synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | Strobe: a snoop is presented this cycle |
| snp_needs_wr | input | 1 | Snoop wants a writable copy |
| snp_inval | input | 1 | Snoop invalidates other copies |
| snp_cache_inv | input | 1 | Snoop is a cache-invalidate maintenance operation |
| snp_cache_maint | input | 1 | Snoop is any cache-maintenance operation |
| snp_needs_resp | input | 1 | Snoop expects a response |
| snp_clean | input | 1 | Snoop is a clean request |
| snp_uncache | input | 1 | Snoop targets uncacheable space |
| snp_express | input | 1 | Snoop travels on the fast forwarding path |
| ent_in_service | input | 1 | Entry's miss has been issued |
| ent_dn_pending | input | 1 | Issued miss is still held in a lower cache |
| ent_pend_mod | input | 1 | Entry expects a writable copy back |
| ent_post_inv | input | 1 | Entry already has an invalidate queued behind the miss |
| ent_head_cinv | input | 1 | Entry's first target is a cache-invalidate |
| rsp_valid | output | 1 | Result outputs carry a decision |
| rsp_respond | output | 1 | Entry will answer the snoop |
| rsp_replay | output | 1 | Copy of the snoop is queued for replay |
| rsp_cache_resp | output | 1 | Mark: a cache is responding |
| rsp_had_wr | output | 1 | Mark: responder held the line writable |
| rsp_satisfied | output | 1 | Mark: snoop is satisfied without a cache response |
| rsp_sharers | output | 1 | Mark: other sharers exist |
| rsp_conv_upg | output | 1 | Convert buffered upgrades to exclusive reads |
| rsp_set_post_inv | output | 1 | Set the entry's post-invalidate flag |
| rsp_set_post_dg | output | 1 | Set the entry's post-downgrade flag |
| rsp_attr_err | output | 1 | Snoop attributes are inconsistent |

## Verification
The bench builds the block with its default OUT_STAGES of 1, so every decision can be sampled at a fixed single-cycle latency. This also puts the latency property inside the generate branch that checks it. Because the decision depends only on thirteen single-bit inputs, the one-stage build allows all 8192 input combinations to be swept against a model written from the requirements. A hand-computed table pins down the ordering path, the early-out path, and the clean and uncacheable corners separately.

// File: rtl/snpdec_pkg.sv
// Package: shared types for the snoop decision unit.
// Assumes: all fields are single-bit qualifiers.
package snpdec_pkg;

    typedef struct packed {
        logic needs_wr;
        logic inval;
        logic cache_inv;
        logic cache_maint;
        logic needs_resp;
        logic clean;
        logic uncache;
        logic express;
    } snoop_attr_t;

    typedef struct packed {
        logic in_service;
        logic dn_pending;
        logic pend_mod;
        logic post_inv;
        logic head_cinv;
    } entry_state_t;

    typedef struct packed {
        logic respond;
        logic replay;
        logic cache_resp;
        logic had_wr;
        logic satisfied;
        logic sharers;
        logic conv_upg;
        logic set_post_inv;
        logic set_post_dg;
        logic attr_err;
    } decision_t;

    localparam int DEC_W = $bits(decision_t);

endpackage

// File: rtl/snp_order.sv
// Module: snp_order
// Decides whether the snoop logically precedes the entry's miss, and whether
// buffered upgrades must be converted. Purely combinational.
// Assumes: inputs are stable for the strobe cycle.
module snp_order
    import snpdec_pkg::*;
(
    input  snoop_attr_t  attr,
    input  entry_state_t ent,
    output logic         snoop_first,
    output logic         conv_upg
);

    // Ordering: unissued miss, or issued but still parked downstream on the fast path.
    always_comb begin
        snoop_first = !ent.in_service || (attr.express && ent.dn_pending);
        conv_upg    = attr.needs_wr || attr.cache_inv;
    end

endmodule

// File: rtl/snp_core.sv
// Module: snp_core
// Forms the full decision from the ordering result, the snoop attributes and
// the entry snapshot. Combinational; the caller qualifies with the strobe.
// Assumes: snoop_first comes from snp_order for the same snoop.
module snp_core
    import snpdec_pkg::*;
(
    input  snoop_attr_t  attr,
    input  entry_state_t ent,
    input  logic         snoop_first,
    input  logic         conv_upg,
    output decision_t    dec
);

    logic early_done;
    logic answer;

    // Early-out when the entry has logically lost the line already.
    always_comb early_done = ent.post_inv || ent.head_cinv;

    // Answer only as the ordering point, for a snoop that wants a reply and is not a clean.
    always_comb answer = ent.pend_mod && attr.needs_resp && !attr.clean;

    // Decision formation along the three paths.
    always_comb begin
        dec          = '0;
        dec.conv_upg = conv_upg;
        dec.attr_err = (attr.needs_wr != attr.inval) && !attr.cache_maint;
        if (!snoop_first) begin
            if (early_done) begin
                dec.respond = 1'b1;
            end else begin
                dec.respond    = answer;
                dec.replay     = ent.pend_mod || attr.inval;
                dec.cache_resp = answer;
                dec.had_wr     = answer;
                dec.satisfied  = !answer && ent.pend_mod && attr.clean;
                dec.set_post_inv = (ent.pend_mod || attr.inval) &&
                                   (attr.needs_wr || attr.inval);
                dec.set_post_dg  = !attr.needs_wr && !attr.uncache;
                dec.sharers      = !attr.needs_wr && !attr.uncache;
            end
        end
    end

    // Immediate checks tying the ordering input to the decision paths.
    always_comb begin
        if (snoop_first) begin
            a_first_quiet_r1: assert (!dec.respond && !dec.replay && !dec.set_post_inv
                                      && !dec.set_post_dg && !dec.sharers);
        end
        if (dec.set_post_inv) begin
            a_postinv_needs_replay_r8: assert (dec.replay);
        end
    end

endmodule

// File: rtl/snp_pipe.sv
// Module: snp_pipe
// Registers the decision for STAGES cycles with a valid bit; an idle stage
// holds zeros so the outputs are quiet between decisions.
// Assumes: STAGES >= 1.
module snp_pipe #(
    parameter int STAGES = 1,
    parameter int WIDTH  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [WIDTH-1:0] in_dat,
    output logic             out_vld,
    output logic [WIDTH-1:0] out_dat
);

    logic             vld_q [STAGES];
    logic [WIDTH-1:0] dat_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic             vld_d;
        logic [WIDTH-1:0] dat_d;
        if (s == 0) begin : g_head
            always_comb begin
                vld_d = in_vld;
                dat_d = in_vld ? in_dat : '0;
            end
        end else begin : g_tail
            always_comb begin
                vld_d = vld_q[s-1];
                dat_d = dat_q[s-1];
            end
        end
        // One register stage with synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end else begin
                vld_q[s] <= vld_d;
                dat_q[s] <= dat_d;
            end
        end
    end

    // Output taps of the last stage.
    always_comb begin
        out_vld = vld_q[STAGES-1];
        out_dat = dat_q[STAGES-1];
    end

endmodule

// File: rtl/snoop_decide.sv
// Module: snoop_decide (top)
// Judges one snoop against one outstanding-miss entry: ordering, response,
// replay, snoop marks, and entry flag updates, delivered OUT_STAGES later.
// Assumes: the entry snapshot is coherent with the strobed snoop.
module snoop_decide
    import snpdec_pkg::*;
#(
    parameter int OUT_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic snp_valid,
    input  logic snp_needs_wr,
    input  logic snp_inval,
    input  logic snp_cache_inv,
    input  logic snp_cache_maint,
    input  logic snp_needs_resp,
    input  logic snp_clean,
    input  logic snp_uncache,
    input  logic snp_express,
    input  logic ent_in_service,
    input  logic ent_dn_pending,
    input  logic ent_pend_mod,
    input  logic ent_post_inv,
    input  logic ent_head_cinv,
    output logic rsp_valid,
    output logic rsp_respond,
    output logic rsp_replay,
    output logic rsp_cache_resp,
    output logic rsp_had_wr,
    output logic rsp_satisfied,
    output logic rsp_sharers,
    output logic rsp_conv_upg,
    output logic rsp_set_post_inv,
    output logic rsp_set_post_dg,
    output logic rsp_attr_err
);

    snoop_attr_t  attr;
    entry_state_t ent;
    logic         snoop_first;
    logic         conv_upg;
    decision_t    dec_c;
    decision_t    dec_q;
    logic [DEC_W-1:0] dec_bits;

    // Bundle the ports into typed structures.
    always_comb begin
        attr = '{needs_wr: snp_needs_wr, inval: snp_inval, cache_inv: snp_cache_inv,
                 cache_maint: snp_cache_maint, needs_resp: snp_needs_resp,
                 clean: snp_clean, uncache: snp_uncache, express: snp_express};
        ent  = '{in_service: ent_in_service, dn_pending: ent_dn_pending,
                 pend_mod: ent_pend_mod, post_inv: ent_post_inv,
                 head_cinv: ent_head_cinv};
    end

    snp_order u_order (
        .attr        (attr),
        .ent         (ent),
        .snoop_first (snoop_first),
        .conv_upg    (conv_upg)
    );

    snp_core u_core (
        .attr        (attr),
        .ent         (ent),
        .snoop_first (snoop_first),
        .conv_upg    (conv_upg),
        .dec         (dec_c)
    );

    snp_pipe #(.STAGES(OUT_STAGES), .WIDTH(DEC_W)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (snp_valid),
        .in_dat  (dec_c),
        .out_vld (rsp_valid),
        .out_dat (dec_bits)
    );

    // Unpack the registered decision onto the ports.
    always_comb begin
        dec_q            = decision_t'(dec_bits);
        rsp_respond      = dec_q.respond;
        rsp_replay       = dec_q.replay;
        rsp_cache_resp   = dec_q.cache_resp;
        rsp_had_wr       = dec_q.had_wr;
        rsp_satisfied    = dec_q.satisfied;
        rsp_sharers      = dec_q.sharers;
        rsp_conv_upg     = dec_q.conv_upg;
        rsp_set_post_inv = dec_q.set_post_inv;
        rsp_set_post_dg  = dec_q.set_post_dg;
        rsp_attr_err     = dec_q.attr_err;
    end

    p_cache_resp_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cache_resp |-> (rsp_had_wr && rsp_respond && rsp_replay));

    p_satisfied_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_satisfied |-> (!rsp_respond && rsp_replay));

    p_downgrade_sharers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_set_post_dg == rsp_sharers);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_respond || rsp_replay || rsp_conv_upg ||
                         rsp_set_post_inv || rsp_set_post_dg || rsp_attr_err));

    p_post_inv_replay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_set_post_inv |-> rsp_replay);

    if (OUT_STAGES == 1) begin : g_lat_chk
        p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
            snp_valid |=> rsp_valid);
    end

endmodule

// File: tb/sim_snoop_decide.sv
module sim_snoop_decide;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    // stim: nw inv cinv cmaint nresp clean unc expr | insvc dpend pm pinv hcinv
    // exp : respond replay cresp hadwr sat sharers conv spi spd err
    localparam logic [22:0] VEC [NVEC] = '{
        {13'b1100_1000_00000, 10'b0000001000},   // R1 not issued, invalidating
        {13'b0000_1001_11000, 10'b0000000000},   // R1 express + downstream pending
        {13'b0000_1000_11100, 10'b1111010010},   // R4 R6 R9 read, pend-mod
        {13'b1100_1000_10100, 10'b1111001100},   // R4 R8 R2 writable, pend-mod
        {13'b0001_1100_10100, 10'b0100110010},   // R7 clean, pend-mod
        {13'b1100_1000_10000, 10'b0100001100},   // R5 R8 invalidate, no pend-mod
        {13'b0000_1000_10000, 10'b0000010010},   // R9 read, no pend-mod
        {13'b0000_1010_10000, 10'b0000000000},   // R9 uncacheable read
        {13'b1100_1000_10110, 10'b1000001000},   // R3 post-invalidate set
        {13'b0000_1000_10001, 10'b1000000000},   // R3 head is cache-invalidate
        {13'b1000_1000_00000, 10'b0000001001},   // R10 mismatch, not maint
        {13'b1011_1000_00000, 10'b0000001000},   // R10 mismatch but maint
        {13'b0000_0000_10100, 10'b0100010010},   // R4 no response needed
        {13'b1100_1001_10100, 10'b1111001100},   // R1 express w/o downstream pending
        {13'b0011_1000_10000, 10'b0000011010}    // R2 cache-invalidate, issued
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snp_valid = 1'b0;
    logic [12:0] stim = '0;
    logic rsp_valid;
    logic [9:0] got;
    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_decide u0 (
        .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid),
        .snp_needs_wr(stim[12]), .snp_inval(stim[11]), .snp_cache_inv(stim[10]),
        .snp_cache_maint(stim[9]), .snp_needs_resp(stim[8]), .snp_clean(stim[7]),
        .snp_uncache(stim[6]), .snp_express(stim[5]), .ent_in_service(stim[4]),
        .ent_dn_pending(stim[3]), .ent_pend_mod(stim[2]), .ent_post_inv(stim[1]),
        .ent_head_cinv(stim[0]),
        .rsp_valid(rsp_valid), .rsp_respond(got[9]), .rsp_replay(got[8]),
        .rsp_cache_resp(got[7]), .rsp_had_wr(got[6]), .rsp_satisfied(got[5]),
        .rsp_sharers(got[4]), .rsp_conv_upg(got[3]), .rsp_set_post_inv(got[2]),
        .rsp_set_post_dg(got[1]), .rsp_attr_err(got[0])
    );

    // Model written from the requirements.
    function automatic logic [9:0] model(input logic [12:0] s);
        logic nw, inv, cinv, cm, nr, cl, un, ex, is, dp, pm, pi, hc;
        logic [9:0] e;
        {nw, inv, cinv, cm, nr, cl, un, ex, is, dp, pm, pi, hc} = s;
        e = '0;
        e[3] = nw | cinv;                                  // R1 R2
        e[0] = (nw != inv) && !cm;                         // R10
        if (is && !(ex && dp)) begin
            if (pi || hc) e[9] = 1'b1;                     // R3
            else begin
                e[9] = pm && nr && !cl;                    // R4
                e[8] = pm || inv;                          // R5
                e[7] = e[9]; e[6] = e[9];                  // R6
                e[5] = pm && cl && !e[9];                  // R7
                e[2] = e[8] && (nw || inv);                // R8
                e[1] = !nw && !un; e[4] = e[1];            // R9
            end
        end
        return e;
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [12:0] s, input logic [9:0] exp, input string tag);
        @(negedge clk);
        stim = s; snp_valid = 1'b1;
        @(negedge clk);
        snp_valid = 1'b0;
        check({tag, " valid R11"}, {9'b0, rsp_valid}, 10'b1);
        check(tag, got, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        stim = 13'h1fff;
        repeat (3) @(negedge clk);
        check("R12 reset outputs", got, 10'b0);
        check("R12 reset valid", {9'b0, rsp_valid}, 10'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after reset", got, 10'b0);
        check("R11 no strobe quiet", {9'b0, rsp_valid}, 10'b0);

        for (int i = 0; i < NVEC; i++) begin
            strobe(VEC[i][22:10], VEC[i][9:0], $sformatf("table[%0d]", i));
        end

        // R11: outputs fall back to zero the cycle after a decision.
        strobe(13'b1100_1000_10100, 10'b1111001100, "R4 before idle");
        @(negedge clk);
        check("R11 idle after decision", {rsp_valid, got[8:0]}, 10'b0);

        // Exhaustive sweep against the requirement model.
        for (int k = 0; k < 8192; k++) begin
            strobe(k[12:0], model(k[12:0]), $sformatf("sweep R1-model %0d", k));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule